// File: doc/BRIEF.md
# Split Nibble/Word Register File

This block keeps eight 4-bit registers and lets the surrounding logic reach them in two ways. Eight nibble read ports and eight nibble write ports each move one 4-bit value. Such a port does not take a binary address. It takes a select vector with one bit per register. A single word read port and a single word write port move all eight registers at once, packed into one 32-bit value.

Reads are combinational and see writes from the same cycle. When a register is written in the current cycle, every read of it returns the value the register will hold after the next edge, not the value it holds now. This applies in both views. The write resolution follows a fixed priority. The word write comes lowest. Nibble ports override it, and a higher-numbered nibble port overrides a lower one. The same priority decides which value is forwarded, separately for each nibble.

Top module: `nsplit_regfile`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge clears all eight registers to zero.
- R2: Nibble write port p writes `nib_wr_data[4p+3:4p]` at the clock edge into every register i whose select bit `nib_wr_sel[8p+i]` is set. With several bits set, all selected registers get the same value. The new value can be read from the following cycle.
- R3: Nibble read port r drives `nib_rd_data[4r+3:4r]`. When only select bit `nib_rd_sel[8r+i]` is set, the output is the value of register i. When all eight of its select bits are clear, the output is zero.
- R4: When several select bits of one nibble read port are set, its output is the bitwise OR of the selected registers' values.
- R5: When a nibble read selects a register that is being written in the same cycle, it returns the winning incoming write data for that register instead of the stored value.
- R6: With `word_rd_en` high, register i appears on `word_rd_data[4i+3:4i]`. With `word_rd_en` low, `word_rd_data` is zero.
- R7: With `word_wr_en` high, register i loads `word_wr_data[4i+3:4i]` at the clock edge.
- R8: When a nibble write and the word write target the same register in the same cycle, the nibble data is stored there. The other registers still take their word nibbles.
- R9: When several nibble write ports target the same register in one cycle, the highest-numbered port's data is stored.
- R10: The word read forwards each nibble separately, using the same priority as the write path (R8, R9).
- R11: A register that no write port targets keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nib_rd_sel | input | 64 | Read port r's select for register i at bit 8r+i |
| nib_rd_data | output | 32 | Read port r's nibble at bits 4r+3:4r |
| nib_wr_sel | input | 64 | Write port p's select for register i at bit 8p+i |
| nib_wr_data | input | 32 | Write port p's nibble at bits 4p+3:4p |
| word_rd_en | input | 1 | Enables the packed word read |
| word_rd_data | output | 32 | All registers packed, register i at bits 4i+3:4i |
| word_wr_en | input | 1 | Writes all registers from word_wr_data |
| word_wr_data | input | 32 | Packed write data, register i at bits 4i+3:4i |

## Verification
The bench goes after the cases where writes collide. A nibble write and the word write can land on the same register, and two or more nibble ports can target one register. Each of these cases is checked both after the edge and through same-cycle forwarding. A wrong priority would store or forward the word nibble, or the lower port's data, in place of the winner. Broken forwarding would return the old contents during the write cycle. A read port that had lost its zero-on-idle behaviour would leak a register value when no select bit is set. A reversed word packing would swap nibbles between registers 0 and 7.

// File: rtl/nsrf_pkg.sv
package nsrf_pkg;
  parameter int unsigned DEF_NREG = 8;
  parameter int unsigned DEF_NW   = 4;
  parameter int unsigned DEF_NRP  = 8;
  parameter int unsigned DEF_NWP  = 8;
endpackage

// File: rtl/nsrf_cell.sv
module nsrf_cell #(
  parameter int unsigned NW  = 4,
  parameter int unsigned NWP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NWP-1:0]    wen,
  input  logic [NWP*NW-1:0] wdata,
  input  logic              word_we,
  input  logic [NW-1:0]     word_nib,
  output logic [NW-1:0]     fwd
);
  logic [NW-1:0] q;
  logic          nib_hit;
  logic          word_lost;

  // Priority: stored value < word write < nibble port 0 < ... < port NWP-1
  function automatic logic [NW-1:0] resolve(
    input logic [NW-1:0]     cur,
    input logic [NWP-1:0]    sel,
    input logic [NWP*NW-1:0] dat,
    input logic              wwe,
    input logic [NW-1:0]     wnib);
    logic [NW-1:0] r;
    r = cur;
    if (wwe) r = wnib;
    for (int p = 0; p < NWP; p++)
      if (sel[p]) r = dat[p*NW +: NW];
    return r;
  endfunction

  assign fwd       = resolve(q, wen, wdata, word_we, word_nib);
  assign nib_hit   = |wen;
  assign word_lost = word_we & nib_hit;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= fwd;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!nib_hit && !word_we) |=> q == $past(q)); // R11
  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (word_we && !nib_hit) |=> q == $past(word_nib)); // R7
  AST_TOP_PORT_WINS: assert property (@(posedge clk) disable iff (rst)
    (word_lost && wen[NWP-1]) |=> q == $past(wdata[(NWP-1)*NW +: NW])); // R9
endmodule

// File: rtl/nsrf_rdmux.sv
module nsrf_rdmux #(
  parameter int unsigned NREG = 8,
  parameter int unsigned NW   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREG-1:0]    ren,
  input  logic [NREG*NW-1:0] fwd_all,
  output logic [NW-1:0]      rdata
);
  function automatic logic [NW-1:0] or_select(
    input logic [NREG-1:0]    s,
    input logic [NREG*NW-1:0] v);
    logic [NW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NREG; i++)
      if (s[i]) acc = acc | v[i*NW +: NW];
    return acc;
  endfunction

  assign rdata = or_select(ren, fwd_all);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ren == '0) |-> (rdata == '0)); // R3
endmodule

// File: rtl/nsplit_regfile.sv
module nsplit_regfile
  import nsrf_pkg::*;
#(
  parameter int unsigned NREG = DEF_NREG,
  parameter int unsigned NW   = DEF_NW,
  parameter int unsigned NRP  = DEF_NRP,
  parameter int unsigned NWP  = DEF_NWP,
  localparam int unsigned WW  = NREG * NW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRP*NREG-1:0] nib_rd_sel,
  output logic [NRP*NW-1:0]   nib_rd_data,
  input  logic [NWP*NREG-1:0] nib_wr_sel,
  input  logic [NWP*NW-1:0]   nib_wr_data,
  input  logic              word_rd_en,
  output logic [WW-1:0]     word_rd_data,
  input  logic              word_wr_en,
  input  logic [WW-1:0]     word_wr_data
);
  logic [WW-1:0]  fwd_vec;
  logic [NWP-1:0] cell_wen [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    for (genvar p = 0; p < NWP; p++) begin : g_sel
      assign cell_wen[i][p] = nib_wr_sel[p*NREG + i];
    end
    nsrf_cell #(.NW(NW), .NWP(NWP)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .wen      (cell_wen[i]),
      .wdata    (nib_wr_data),
      .word_we  (word_wr_en),
      .word_nib (word_wr_data[i*NW +: NW]),
      .fwd      (fwd_vec[i*NW +: NW])
    );
  end

  for (genvar r = 0; r < NRP; r++) begin : g_rd
    nsrf_rdmux #(.NREG(NREG), .NW(NW)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .ren     (nib_rd_sel[r*NREG +: NREG]),
      .fwd_all (fwd_vec),
      .rdata   (nib_rd_data[r*NW +: NW])
    );
  end

  assign word_rd_data = word_rd_en ? fwd_vec : '0;

  AST_WORD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !word_rd_en |-> word_rd_data == '0); // R6
  AST_WORD_FWD: assert property (@(posedge clk) disable iff (rst)
    (word_rd_en && word_wr_en && nib_wr_sel == '0) |-> word_rd_data == word_wr_data); // R10
endmodule

// File: tb/nsplit_regfile_test.sv
`timescale 1ns/1ps
module nsplit_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] nib_rd_sel = '0;
  logic [31:0] nib_rd_data;
  logic [63:0] nib_wr_sel = '0;
  logic [31:0] nib_wr_data = '0;
  logic        word_rd_en = 1'b0;
  logic [31:0] word_rd_data;
  logic        word_wr_en = 1'b0;
  logic [31:0] word_wr_data = '0;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl [8];

  always #10 clk = ~clk;

  nsplit_regfile uut (
    .clk(clk), .rst(rst),
    .nib_rd_sel(nib_rd_sel), .nib_rd_data(nib_rd_data),
    .nib_wr_sel(nib_wr_sel), .nib_wr_data(nib_wr_data),
    .word_rd_en(word_rd_en), .word_rd_data(word_rd_data),
    .word_wr_en(word_wr_en), .word_wr_data(word_wr_data)
  );

  // Value register i holds after the edge, from the stated priority
  function automatic logic [3:0] next_val(input int i);
    logic [3:0] v;
    v = mdl[i];
    if (word_wr_en) v = word_wr_data[4*i +: 4];
    for (int p = 0; p < 8; p++)
      if (nib_wr_sel[8*p + i]) v = nib_wr_data[4*p +: 4];
    return v;
  endfunction

  function automatic logic written(input int i);
    logic w;
    w = word_wr_en;
    for (int p = 0; p < 8; p++) w = w | nib_wr_sel[8*p + i];
    return w;
  endfunction

  function automatic logic [7:0] rand_sel();
    case ($urandom % 4)
      0: return 8'h00;
      1, 2: return 8'h01 << ($urandom % 8);
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Inputs are already set; check all read ports mid-cycle, then clock
  task automatic run_cycle(input string tag);
    logic [31:0] wexp;
    #1;
    for (int r = 0; r < 8; r++) begin
      logic [3:0] e;
      logic       fw;
      string      t;
      e = '0; fw = 1'b0;
      for (int i = 0; i < 8; i++)
        if (nib_rd_sel[8*r + i]) begin
          e  = e | next_val(i);
          fw = fw | written(i);
        end
      if (tag != "") t = tag;
      else if (nib_rd_sel[8*r +: 8] == 0) t = "R3";
      else if (fw) t = "R5";
      else if ($countones(nib_rd_sel[8*r +: 8]) > 1) t = "R4";
      else t = "R3";
      chk({28'd0, nib_rd_data[4*r +: 4]}, {28'd0, e}, t);
    end
    wexp = '0;
    if (word_rd_en)
      for (int i = 0; i < 8; i++) wexp[4*i +: 4] = next_val(i);
    chk(word_rd_data, wexp,
        tag != "" ? tag : ((word_wr_en || nib_wr_sel != 0) ? "R10" : "R6"));
    @(posedge clk);
    for (int i = 0; i < 8; i++) mdl[i] = rst ? 4'h0 : next_val(i);
    @(negedge clk);
  endtask

  task automatic idle();
    nib_rd_sel = '0; nib_wr_sel = '0; nib_wr_data = '0;
    word_rd_en = 1'b0; word_wr_en = 1'b0; word_wr_data = '0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) mdl[i] = 4'h5;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) mdl[i] = 4'h0;
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible on word read
    idle(); word_rd_en = 1'b1;
    run_cycle("R1");
    // R2: one port, two registers
    idle(); nib_wr_sel[8*3 +: 8] = 8'b0010_0100; nib_wr_data[4*3 +: 4] = 4'hA;
    run_cycle("R2");
    idle(); word_rd_en = 1'b1; nib_rd_sel[8*0 +: 8] = 8'b0010_0000;
    run_cycle("R2");
    // R7 then R6 layout
    idle(); word_wr_en = 1'b1; word_wr_data = 32'h7654_3210;
    run_cycle("R7");
    idle(); word_rd_en = 1'b1; nib_rd_sel[8*7 +: 8] = 8'h80;
    run_cycle("R6");
    // R8: nibble beats word
    idle(); word_wr_en = 1'b1; word_wr_data = 32'hFFFF_FFFF;
    nib_wr_sel[8*0 +: 8] = 8'h02; nib_wr_data[4*0 +: 4] = 4'h3;
    run_cycle("R8");
    idle(); word_rd_en = 1'b1;
    run_cycle("R8");
    // R9: highest port wins
    idle(); nib_wr_sel[8*2 +: 8] = 8'h10; nib_wr_data[4*2 +: 4] = 4'h1;
    nib_wr_sel[8*6 +: 8] = 8'h10; nib_wr_data[4*6 +: 4] = 4'h9;
    run_cycle("R9");
    idle(); word_rd_en = 1'b1; nib_rd_sel[8*4 +: 8] = 8'h10;
    run_cycle("R9");
    // R10: forwarded word read with mixed priorities
    idle(); word_rd_en = 1'b1; word_wr_en = 1'b1; word_wr_data = 32'h1357_9BDF;
    nib_wr_sel[8*1 +: 8] = 8'h81; nib_wr_data[4*1 +: 4] = 4'h6;
    nib_wr_sel[8*5 +: 8] = 8'h80; nib_wr_data[4*5 +: 4] = 4'hC;
    run_cycle("R10");
    // R5: forwarded nibble read
    idle(); nib_wr_sel[8*4 +: 8] = 8'h08; nib_wr_data[4*4 +: 4] = 4'hE;
    nib_rd_sel[8*2 +: 8] = 8'h08;
    run_cycle("R5");
    // R4: OR of several registers
    idle(); nib_rd_sel[8*1 +: 8] = 8'h0F;
    run_cycle("R4");
    // R11: only register 0 written, others hold
    idle(); nib_wr_sel[8*7 +: 8] = 8'h01; nib_wr_data[4*7 +: 4] = 4'h4;
    run_cycle("R11");
    idle(); word_rd_en = 1'b1;
    run_cycle("R11");
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      for (int r = 0; r < 8; r++) nib_rd_sel[8*r +: 8] = rand_sel();
      for (int p = 0; p < 8; p++) begin
        nib_wr_sel[8*p +: 8] = ($urandom % 4 == 0) ? rand_sel() : 8'h00;
        nib_wr_data[4*p +: 4] = 4'($urandom);
      end
      word_rd_en   = ($urandom % 2) == 0;
      word_wr_en   = ($urandom % 5) == 0;
      word_wr_data = $urandom;
      run_cycle("");
    end
    // R1: reset after traffic
    idle(); rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) mdl[i] = 4'h0;
    @(negedge clk);
    rst = 1'b0; word_rd_en = 1'b1;
    run_cycle("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule